// File: doc/BRIEF.md
# Power-Good Start-Up Sequencer

This block decides when a voltage regulator may report its output as good. It stays idle until a synchronous detect input says that the upstream supplies are in regulation. On the first clock edge that sees detect high, it stores the voltage-ID code on the VID bus, and that stored code becomes the regulation target. It then counts a fixed number of switching-clock cycles, 3072 by default. Power-good can only rise once that count has run out.

After the delay, power-good follows two live conditions. It is high while the in-regulation flag is true and no VID or mode transition is under way. A transition strobe masks the output for as long as the strobe is high. When the strobe ends, the output comes back without restarting the delay. If detect drops, the block returns to idle, so the next detect starts the sequence again. A fault input latches the block into a fault state that only reset clears.

Top module: `pwrgood_seq`

## Requirements
- R1: During and right after a synchronous active-high reset, pgood and timer_done are 0, vid_cap is 0, and the block is idle.
- R2: On the first clock edge with detect high in the idle state and no fault, vid_cap loads the VID bus. Later VID changes do not alter vid_cap until the block passes through idle again.
- R3: timer_done rises on exactly the DELAY_CYCLES-th clock edge after the capture edge, provided detect stays high. It stays 0 before that edge.
- R4: pgood is high only while timer_done is high, in_reg is 1 and trans is 0. During the delay it stays 0 whatever in_reg does.
- R5: While trans is 1, pgood is 0 in every cycle, including cycles during the delay. The delay count is not disturbed by the strobe. After trans falls, pgood returns in the same cycle if in_reg is 1, with no new delay.
- R6: With timer_done high, in_reg at 0 drives pgood to 0 at once, and pgood returns as soon as in_reg is 1 again.
- R7: detect at 0 on a clock edge outside the fault state clears timer_done and pgood and returns the block to idle. A later detect recaptures the VID and runs the full delay again.
- R8: fault at 1 on any clock edge latches the fault state. From the next cycle until reset, pgood and timer_done are 0, and neither detect nor VID has any effect (vid_cap does not load).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock; also times the delay |
| rst | input | 1 | Synchronous reset, active high |
| detect | input | 1 | Upstream supplies in regulation (enable current seen) |
| vid | input | VID_W | Voltage-ID code presented by the system |
| trans | input | 1 | High for the whole of a VID or mode transition |
| fault | input | 1 | Fault request, latched until reset |
| in_reg | input | 1 | Output is inside the regulation window |
| vid_cap | output | VID_W | VID code held as the regulation target |
| pgood | output | 1 | Power-good indication |
| timer_done | output | 1 | Start-up delay has expired |

## Verification
Each input pattern targets one question about the block.

- **Clean start-up:** detect held with the VID bus changing after capture. This shows that the capture happens on the detect edge alone, and places the timer expiry on one exact edge rather than one early or late.
- **Transition pulses:** strobes during the delay and after it. These separate a mask on the output from a restart of the count. Holding in_reg low as the strobe ends tells a plain release apart from a release gated by regulation.
- **Detect dropping:** detect falls in the middle of the count and again after expiry. This checks that the timer is really cleared and the VID recaptured.
- **Fault timing:** fault raised while idle and again while good. This shows that it blocks capture and holds until reset.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_GOOD  = 2'd2,
    ST_FAULT = 2'd3
  } pgs_state_t;

  // True on the last count value of a delay of 'span' cycles (count starts at 0).
  function automatic logic span_reached(input int unsigned cnt, input int unsigned span);
    return cnt == span - 1;
  endfunction

  // Power-good qualification once the delay has expired.
  function automatic logic good_allowed(input logic expired, input logic regulated,
                                        input logic in_transition);
    return expired && regulated && !in_transition;
  endfunction

endpackage

// File: rtl/pgs_delay_timer.sv
module pgs_delay_timer
  import pgs_pkg::*;
#(
  parameter int DELAY_CYCLES = 3072
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic last
);
  localparam int CW = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;

  logic [CW-1:0] cnt_q;

  assign last = span_reached(32'(cnt_q), DELAY_CYCLES);

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (run && !last)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pgs_vid_hold.sv
module pgs_vid_hold #(
  parameter int VID_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [VID_W-1:0] vid_in,
  output logic [VID_W-1:0] vid_q
);
  always_ff @(posedge clk) begin
    if (rst)
      vid_q <= '0;
    else if (load)
      vid_q <= vid_in;
  end
endmodule

// File: rtl/pgs_state_ctl.sv
module pgs_state_ctl
  import pgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       detect,
  input  logic       fault,
  input  logic       timer_last,
  output pgs_state_t state,
  output logic       capture,
  output logic       timer_clear,
  output logic       timer_run
);
  pgs_state_t state_d;

  assign capture     = (state == ST_IDLE) && detect && !fault;
  assign timer_run   = (state == ST_COUNT);
  assign timer_clear = (state != ST_COUNT);

  always_comb begin
    state_d = state;
    if (fault) begin
      state_d = ST_FAULT;
    end else begin
      unique case (state)
        ST_IDLE:  if (detect) state_d = ST_COUNT;
        ST_COUNT: if (!detect) state_d = ST_IDLE;
                  else if (timer_last) state_d = ST_GOOD;
        ST_GOOD:  if (!detect) state_d = ST_IDLE;
        ST_FAULT: state_d = ST_FAULT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      state <= ST_IDLE;
    else
      state <= state_d;
  end
endmodule

// File: rtl/pwrgood_seq.sv
module pwrgood_seq
  import pgs_pkg::*;
#(
  parameter int VID_W        = 6,
  parameter int DELAY_CYCLES = 3072
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             detect,
  input  logic [VID_W-1:0] vid,
  input  logic             trans,
  input  logic             fault,
  input  logic             in_reg,
  output logic [VID_W-1:0] vid_cap,
  output logic             pgood,
  output logic             timer_done
);
  pgs_state_t state;
  logic       capture_evt;
  logic       timer_clear;
  logic       timer_run;
  logic       timer_last;
  logic       fault_hold;

  pgs_state_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .detect      (detect),
    .fault       (fault),
    .timer_last  (timer_last),
    .state       (state),
    .capture     (capture_evt),
    .timer_clear (timer_clear),
    .timer_run   (timer_run)
  );

  pgs_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (timer_clear),
    .run   (timer_run),
    .last  (timer_last)
  );

  pgs_vid_hold #(.VID_W(VID_W)) u_vid (
    .clk    (clk),
    .rst    (rst),
    .load   (capture_evt),
    .vid_in (vid),
    .vid_q  (vid_cap)
  );

  assign fault_hold = (state == ST_FAULT);
  assign timer_done = (state == ST_GOOD);
  assign pgood      = good_allowed(timer_done, in_reg, trans);
endmodule

// File: rtl/pwrgood_seq_chk.sv
module pwrgood_seq_chk #(
  parameter int VID_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             detect,
  input logic [VID_W-1:0] vid,
  input logic             trans,
  input logic             fault,
  input logic             in_reg,
  input logic [VID_W-1:0] vid_cap,
  input logic             pgood,
  input logic             timer_done,
  input logic             capture_evt,
  input logic             timer_last,
  input logic             fault_hold
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pgood && !timer_done && vid_cap == '0));

  assert_vid_load_R2: assert property (@(posedge clk) disable iff (rst)
    capture_evt |=> vid_cap == $past(vid));

  assert_vid_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !capture_evt |=> $stable(vid_cap));

  assert_done_from_timer_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(timer_done) |-> $past(timer_last));

  assert_pgood_gated_R4: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (timer_done && in_reg));

  assert_trans_mask_R5: assert property (@(posedge clk) disable iff (rst)
    trans |-> !pgood);

  assert_detect_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (!detect && !fault) |=> (!timer_done && !pgood));

  assert_fault_entry_R8: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault_hold);

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fault_hold |=> (fault_hold && !pgood && !timer_done && $stable(vid_cap)));
endmodule

bind pwrgood_seq pwrgood_seq_chk #(.VID_W(VID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .detect      (detect),
  .vid         (vid),
  .trans       (trans),
  .fault       (fault),
  .in_reg      (in_reg),
  .vid_cap     (vid_cap),
  .pgood       (pgood),
  .timer_done  (timer_done),
  .capture_evt (capture_evt),
  .timer_last  (timer_last),
  .fault_hold  (fault_hold)
);

// File: tb/pwrgood_seq_test.sv
`timescale 1ns/1ps
module pwrgood_seq_test;
  localparam int VID_W = 6;
  localparam int DLY   = 3072;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             detect = 1'b0;
  logic [VID_W-1:0] vid = '0;
  logic             trans = 1'b0;
  logic             fault = 1'b0;
  logic             in_reg = 1'b0;
  logic [VID_W-1:0] vid_cap;
  logic             pgood;
  logic             timer_done;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwrgood_seq #(.VID_W(VID_W), .DELAY_CYCLES(DLY)) uut (
    .clk(clk), .rst(rst), .detect(detect), .vid(vid), .trans(trans),
    .fault(fault), .in_reg(in_reg), .vid_cap(vid_cap), .pgood(pgood),
    .timer_done(timer_done)
  );

  // Advance n rising edges; return 1 ns after the last one.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; detect = 1'b0; trans = 1'b0; fault = 1'b0; in_reg = 1'b0; vid = '0;
    step(2);
    rst = 1'b0;
    #0.5;
  endtask

  // Raise detect with a code; on return the capture edge has passed.
  task automatic begin_startup(input logic [VID_W-1:0] code);
    vid = code; detect = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "pgood after reset", pgood, 0);
    check("R1", "timer_done after reset", timer_done, 0);
    check("R1", "vid_cap after reset", vid_cap, 0);
  endtask

  task automatic t_startup();
    do_reset();
    in_reg = 1'b1;
    begin_startup(6'h2A);
    vid = 6'h15;
    #0.5;
    check("R2", "vid captured on detect edge", vid_cap, 6'h2A);
    check("R4", "pgood low during delay", pgood, 0);
    step(DLY - 1);
    check("R3", "timer_done one edge before expiry", timer_done, 0);
    check("R4", "pgood one edge before expiry", pgood, 0);
    step(1);
    check("R3", "timer_done at expiry edge", timer_done, 1);
    check("R4", "pgood after expiry", pgood, 1);
    check("R2", "later vid ignored", vid_cap, 6'h2A);
  endtask

  task automatic t_regulation();
    in_reg = 1'b0; #0.5;
    check("R6", "pgood drops with in_reg", pgood, 0);
    step(3);
    check("R6", "pgood stays low out of regulation", pgood, 0);
    check("R6", "timer_done kept", timer_done, 1);
    in_reg = 1'b1; #0.5;
    check("R6", "pgood back with in_reg", pgood, 1);
  endtask

  task automatic t_transition();
    do_reset();
    in_reg = 1'b1;
    begin_startup(6'h0C);
    step(100);
    trans = 1'b1;
    step(10);
    check("R5", "pgood masked during delay", pgood, 0);
    trans = 1'b0;
    step(DLY - 111);
    check("R5", "delay not restarted, not early", timer_done, 0);
    step(1);
    check("R5", "delay expiry unchanged by strobe", timer_done, 1);
    check("R5", "pgood up after expiry", pgood, 1);
    trans = 1'b1; #0.5;
    check("R5", "pgood masked at strobe start", pgood, 0);
    step(5);
    check("R5", "pgood masked through strobe", pgood, 0);
    check("R5", "timer_done kept during strobe", timer_done, 1);
    trans = 1'b0; #0.5;
    check("R5", "pgood returns after strobe", pgood, 1);
    trans = 1'b1; step(3); in_reg = 1'b0; trans = 1'b0; #0.5;
    check("R5", "strobe end out of regulation", pgood, 0);
    step(2); in_reg = 1'b1; #0.5;
    check("R5", "pgood once regulated", pgood, 1);
  endtask

  task automatic t_detect_drop();
    do_reset();
    in_reg = 1'b1;
    begin_startup(6'h31);
    step(500);
    detect = 1'b0;
    step(1);
    check("R7", "timer_done low after drop", timer_done, 0);
    step(10);
    begin_startup(6'h07);
    #0.5;
    check("R7", "vid recaptured", vid_cap, 6'h07);
    step(DLY - 1);
    check("R7", "full delay again, not early", timer_done, 0);
    step(1);
    check("R7", "full delay again, expiry", timer_done, 1);
    check("R7", "pgood after restart", pgood, 1);
    detect = 1'b0;
    step(1);
    check("R7", "pgood cleared on drop from good", pgood, 0);
    check("R7", "timer cleared on drop from good", timer_done, 0);
  endtask

  task automatic t_fault();
    do_reset();
    in_reg = 1'b1;
    fault = 1'b1; vid = 6'h33; detect = 1'b1;
    step(1);
    fault = 1'b0; #0.5;
    check("R8", "no capture under fault", vid_cap, 0);
    step(DLY + 5);
    check("R8", "timer held under fault", timer_done, 0);
    check("R8", "pgood held under fault", pgood, 0);
    check("R8", "vid ignored under fault", vid_cap, 0);
    do_reset();
    in_reg = 1'b1;
    begin_startup(6'h1E);
    step(DLY);
    check("R8", "good before fault", pgood, 1);
    fault = 1'b1;
    step(1);
    fault = 1'b0; #0.5;
    check("R8", "pgood low after fault", pgood, 0);
    step(20);
    check("R8", "fault latched", pgood, 0);
    check("R8", "timer_done low in fault", timer_done, 0);
    do_reset();
    check("R1", "reset clears fault", timer_done, 0);
    in_reg = 1'b1;
    begin_startup(6'h05);
    #0.5;
    check("R8", "capture works after reset", vid_cap, 6'h05);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_regulation();
    t_transition();
    t_detect_drop();
    t_fault();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule